// File: doc/BRIEF.md
# Adaptive Clock Frequency Tuner

The tuner steps a digital frequency code that feeds an external DAC and oscillator. It sets the code from timing checks on a monitored critical path. Each check reports one of three outcomes. If the path finished early, the clock can run faster. If it finished late, the clock must slow down. If it was on time, the code is held. The code moves by at most one step per accepted check. It stops at both ends of its range and never wraps.

Calibration has two phases.

- **Startup phase.** This runs after reset, and again whenever a recalibration request arrives (for example after a supply-voltage change). The tuner drives a force line so that the datapath sees its worst-case input vector, and it uses every check that is not blocked. The phase ends on an on-time result, or on the second reversal of step direction in a row. A done flag is then raised.
- **In-situ phase.** Calibration then continues, but a check is used only in a cycle where the external detector reports that the worst-case vector appeared in normal traffic.

After every code change, the tuner blocks datapath evaluation for a programmable number of settle cycles. Checks that arrive during that window are dropped.

Top module: `clk_tune_ctrl`

## Requirements
- R1: During and right after reset, `freqCode` equals 128, `forceWc` is 1, `calDone` is 0 and `evalInhibit` is 0.
- R2: `chkResult` is encoded as 2'b01 = early, 2'b10 = late, and 2'b00 or 2'b11 = on time. An accepted early check raises `freqCode` by one in the next cycle. An accepted late check lowers it by one. An accepted on-time check leaves it unchanged.
- R3: `freqCode` saturates. An early check at 255 leaves it at 255, and a late check at 0 leaves it at 0.
- R4: When `freqCode` changes, `evalInhibit` is high for exactly `settleCycles` cycles, starting in the cycle where the new code first appears. It stays low when an accepted check does not change the code.
- R5: A check that arrives while `evalInhibit` is high is ignored, and the code does not move.
- R6: In the startup phase `forceWc` is 1, and checks are accepted whatever the value of `wcDetect`. An accepted on-time check ends the phase: in the next cycle `calDone` is 1 and `forceWc` is 0.
- R7: In the startup phase, a step whose direction is opposite to the previous step counts as a reversal. A step in the same direction clears the reversal count. The second reversal in a row ends the phase in the next cycle, and that step is still applied to the code.
- R8: In the in-situ phase, a check is accepted only when `wcDetect` is 1 in the same cycle. Without `wcDetect`, the code does not move.
- R9: A `calStart` pulse re-enters the startup phase in the next cycle (`forceWc` 1, `calDone` 0). It keeps the current code and clears the reversal history. Any check in the same cycle is ignored.
- R10: `freqCode` never changes by more than one step between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calStart | input | 1 | Request to restart the startup calibration |
| settleCycles | input | 4 | Number of cycles evaluation stays blocked after a code change |
| wcDetect | input | 1 | Worst-case vector seen in normal traffic this cycle |
| chkValid | input | 1 | A timing check result is present |
| chkResult | input | 2 | Check outcome: 01 early, 10 late, 00/11 on time |
| forceWc | output | 1 | Force the worst-case vector into the datapath |
| freqCode | output | 8 | Frequency code to the DAC/oscillator |
| evalInhibit | output | 1 | Block datapath evaluation while the clock settles |
| calDone | output | 1 | Startup calibration finished; in-situ phase active |

## Verification
The hardest situations to reach are the ends of the code range and the reversal-based exit from the startup phase.

Both code limits lie more than a hundred accepted steps from the reset code. The stimulus gets there by running the in-situ phase with a zero settle count, so that every cycle can carry an accepted check. It pushes the code to 255 and then down to 0, and drives extra checks at each limit.

The reversal exit depends on step history that only matters inside the startup phase. An up, down, up pattern is driven to end the phase. After a `calStart`, a pattern with a single reversal is driven to show that history from before the restart is not counted.

// File: rtl/clk_tune_pkg.sv
package clk_tune_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic incr;
    logic decr;
  } stepCmd_t;

  typedef enum logic {
    PH_START  = 1'b0,
    PH_INSITU = 1'b1
  } phase_t;

  localparam logic [1:0] RES_EARLY = 2'b01;
  localparam logic [1:0] RES_LATE  = 2'b10;

endpackage

// File: rtl/tune_datapath.sv
module tune_datapath
  import clk_tune_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SETTLE_W   = 4,
  parameter int unsigned RESET_CODE = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  stepCmd_t            cmd,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic [CODE_W-1:0]   freqCode,
  output logic                evalInhibit
);

  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(RESET_CODE);

  logic [SETTLE_W-1:0] settleCnt;
  logic                moveUp;
  logic                moveDn;
  logic [CODE_W-1:0]   codeNext;

  always_comb begin
    moveUp   = cmd.incr && (freqCode != CODE_MAX);
    moveDn   = cmd.decr && (freqCode != '0);
    codeNext = freqCode;
    if (moveUp)      codeNext = freqCode + 1'b1;
    else if (moveDn) codeNext = freqCode - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqCode  <= CODE_INIT;
      settleCnt <= '0;
    end else begin
      freqCode <= codeNext;
      if (moveUp || moveDn)     settleCnt <= settleCycles;
      else if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
    end
  end

  assign evalInhibit = (settleCnt != '0);

endmodule

// File: rtl/tune_control.sv
module tune_control
  import clk_tune_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       calStart,
  input  logic       wcDetect,
  input  logic       chkValid,
  input  logic [1:0] chkResult,
  input  logic       evalInhibit,
  output stepCmd_t   cmd,
  output logic       forceWc,
  output logic       calDone
);

  phase_t phase;
  logic   dirPrevUp;
  logic   havePrev;
  logic   revSeen;
  logic   accept;
  logic   isUp;
  logic   isDn;
  logic   reversal;

  always_comb begin
    isUp     = (chkResult == RES_EARLY);
    isDn     = (chkResult == RES_LATE);
    accept   = chkValid && !evalInhibit && !calStart &&
               ((phase == PH_START) || wcDetect);
    cmd.incr = accept && isUp;
    cmd.decr = accept && isDn;
    reversal = havePrev && (isUp != dirPrevUp);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_START;
      dirPrevUp <= 1'b0;
      havePrev  <= 1'b0;
      revSeen   <= 1'b0;
    end else if (calStart) begin
      phase    <= PH_START;
      havePrev <= 1'b0;
      revSeen  <= 1'b0;
    end else if (accept && (phase == PH_START)) begin
      if (!isUp && !isDn) begin
        phase <= PH_INSITU;
      end else begin
        if (reversal && revSeen) phase <= PH_INSITU;
        revSeen   <= reversal;
        dirPrevUp <= isUp;
        havePrev  <= 1'b1;
      end
    end
  end

  assign forceWc = (phase == PH_START);
  assign calDone = (phase == PH_INSITU);

endmodule

// File: rtl/clk_tune_ctrl.sv
module clk_tune_ctrl
  import clk_tune_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SETTLE_W   = 4,
  parameter int unsigned RESET_CODE = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                calStart,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                wcDetect,
  input  logic                chkValid,
  input  logic [1:0]          chkResult,
  output logic                forceWc,
  output logic [CODE_W-1:0]   freqCode,
  output logic                evalInhibit,
  output logic                calDone
);

  stepCmd_t stepCmd;

  tune_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .calStart    (calStart),
    .wcDetect    (wcDetect),
    .chkValid    (chkValid),
    .chkResult   (chkResult),
    .evalInhibit (evalInhibit),
    .cmd         (stepCmd),
    .forceWc     (forceWc),
    .calDone     (calDone)
  );

  tune_datapath #(
    .CODE_W     (CODE_W),
    .SETTLE_W   (SETTLE_W),
    .RESET_CODE (RESET_CODE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (stepCmd),
    .settleCycles (settleCycles),
    .freqCode     (freqCode),
    .evalInhibit  (evalInhibit)
  );

endmodule

// File: rtl/clk_tune_ctrl_chk.sv
module clk_tune_ctrl_chk #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned SETTLE_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                calStart,
  input logic [SETTLE_W-1:0] settleCycles,
  input logic                wcDetect,
  input logic                chkValid,
  input logic [1:0]          chkResult,
  input logic                forceWc,
  input logic [CODE_W-1:0]   freqCode,
  input logic                evalInhibit,
  input logic                calDone
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode == $past(freqCode)) || (freqCode == CODE_W'($past(freqCode) + 1'b1)) ||
    (freqCode == CODE_W'($past(freqCode) - 1'b1))); // R10

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(freqCode) == CODE_MAX) |-> (freqCode != '0)); // R3

  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    ($past(freqCode) == '0) |-> (freqCode != CODE_MAX)); // R3

  AST_ONTIME_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && ((chkResult == 2'b00) || (chkResult == 2'b11))) |=> $stable(freqCode)); // R2

  AST_INHIBIT_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(freqCode) && ($past(settleCycles) != '0)) |-> evalInhibit); // R4

  AST_FROZEN_WHILE_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    evalInhibit |=> $stable(freqCode)); // R5

  AST_INSITU_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && !wcDetect) |=> $stable(freqCode)); // R8

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    forceWc != calDone); // R6

  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    calStart |=> (forceWc && !calDone && $stable(freqCode))); // R9

endmodule

bind clk_tune_ctrl clk_tune_ctrl_chk #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_chk (.*);

// File: tb/tb_clk_tune_ctrl.sv
module tb_clk_tune_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       calStart;
  logic [3:0] settleCycles;
  logic       wcDetect;
  logic       chkValid;
  logic [1:0] chkResult;
  logic       forceWc;
  logic [7:0] freqCode;
  logic       evalInhibit;
  logic       calDone;

  int errors = 0;
  int checks = 0;
  int expCode;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_tune_ctrl dut (
    .clk(clk), .rstN(rstN), .calStart(calStart), .settleCycles(settleCycles),
    .wcDetect(wcDetect), .chkValid(chkValid), .chkResult(chkResult),
    .forceWc(forceWc), .freqCode(freqCode), .evalInhibit(evalInhibit), .calDone(calDone)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock with the given inputs; returns 1 ns after the edge
  task automatic cyc(input bit v, input logic [1:0] res, input bit wc, input bit start);
    chkValid = v; chkResult = res; wcDetect = wc; calStart = start;
    @(posedge clk); #1;
    chkValid = 0; chkResult = 2'b00; wcDetect = 0; calStart = 0;
  endtask

  task automatic testReset();
    chk("R1 code", freqCode, 128);
    chk("R1 forceWc", forceWc, 1);
    chk("R1 calDone", calDone, 0);
    chk("R1 inhibit", evalInhibit, 0);
  endtask

  task automatic testStartup();
    cyc(1, 2'b01, 0, 0); chk("R6 forced accept, R2 up", freqCode, 129);
    cyc(1, 2'b01, 0, 0); chk("R2 up", freqCode, 130);
    cyc(1, 2'b10, 0, 0); chk("R2 down", freqCode, 129);
    chk("R7 one reversal not done", calDone, 0);
    cyc(1, 2'b01, 0, 0); chk("R7 step applied", freqCode, 130);
    chk("R7 done after two reversals", calDone, 1);
    chk("R7 force released", forceWc, 0);
  endtask

  task automatic testInSitu();
    cyc(1, 2'b01, 0, 0); chk("R8 no detect ignored", freqCode, 130);
    cyc(1, 2'b01, 1, 0); chk("R8 detect accepted", freqCode, 131);
    cyc(1, 2'b11, 1, 0); chk("R2 code 11 holds", freqCode, 131);
    cyc(1, 2'b00, 1, 0); chk("R2 code 00 holds", freqCode, 131);
    chk("R4 no inhibit without change", evalInhibit, 0);
  endtask

  task automatic testSettle();
    settleCycles = 4'd3;
    cyc(1, 2'b01, 1, 0); chk("R4 code", freqCode, 132);
    chk("R4 inhibit cycle1", evalInhibit, 1);
    cyc(1, 2'b01, 1, 0); chk("R5 check ignored", freqCode, 132);
    chk("R4 inhibit cycle2", evalInhibit, 1);
    cyc(0, 2'b00, 0, 0); chk("R4 inhibit cycle3", evalInhibit, 1);
    cyc(0, 2'b00, 0, 0); chk("R4 inhibit released", evalInhibit, 0);
    settleCycles = 4'd0;
  endtask

  task automatic testRestart();
    cyc(1, 2'b01, 1, 1);
    chk("R9 code kept", freqCode, 132);
    chk("R9 forceWc", forceWc, 1);
    chk("R9 calDone cleared", calDone, 0);
    cyc(1, 2'b10, 0, 0); chk("R9 step", freqCode, 131);
    cyc(1, 2'b01, 0, 0); chk("R9 step", freqCode, 132);
    chk("R9 history cleared, not done", calDone, 0);
    cyc(1, 2'b00, 0, 0); chk("R6 hold ends startup", calDone, 1);
    chk("R6 force off", forceWc, 0);
    chk("R6 code held", freqCode, 132);
  endtask

  task automatic testSaturate();
    expCode = 132;
    for (int i = 0; i < 127; i++) begin
      cyc(1, 2'b01, 1, 0);
      expCode = (expCode < 255) ? expCode + 1 : 255;
      chk("R10 up step", freqCode, expCode);
    end
    chk("R3 top", freqCode, 255);
    for (int i = 0; i < 259; i++) begin
      cyc(1, 2'b10, 1, 0);
      expCode = (expCode > 0) ? expCode - 1 : 0;
      chk("R10 down step", freqCode, expCode);
    end
    chk("R3 bottom", freqCode, 0);
  endtask

  initial begin
    rstN = 0; calStart = 0; settleCycles = 4'd0; wcDetect = 0;
    chkValid = 0; chkResult = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1;
    @(posedge clk); #1;
    testReset();
    testStartup();
    testInSitu();
    testSettle();
    testRestart();
    testSaturate();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule